// File: doc/BRIEF.md
# Speculative Reorder Buffer with In-Order Commit

This block is a circular buffer that keeps in-flight instructions in the order they were issued. Instructions may finish out of order, but they retire strictly in program order. At issue, a free slot is claimed and its index is returned as a tag. Execution results come back on a broadcast bus that carries that tag. Consumers can read a finished value by tag before it retires. The head slot drives the architectural side effects: a register-file write, a memory store, or a pipeline-wide flush with a fetch redirect.

Each slot records an instruction kind, a destination register, a result value, an address, a ready flag, a fault flag and a misprediction flag. The address is the store address for a store and the correct successor address for a branch. Faults and mispredictions raised by speculative work are only recorded in the slot. They take effect when that slot reaches the head. Because stores go out only at retirement, memory sees them strictly in program order.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: alloc_ready is 1, alloc_tag is 0, and rf_we, mem_we, flush, redirect_valid, exc_take and look_ready are all 0.
- R2: Tags are handed out consecutively modulo DEPTH, starting at 0. alloc_ready is 0 when DEPTH slots are occupied and the head is not retiring, and also in a flush cycle. An allocation takes effect only when alloc_valid and alloc_ready are both 1.
- R3: At most one slot retires per cycle. Retirement happens only when the oldest slot has received its result, so results that arrive out of order still retire in issue order.
- R4: A retiring register operation (kind 2'd0) without a fault asserts rf_we, with rf_idx set to its destination and rf_data set to its result.
- R5: A retiring store (kind 2'd1) without a fault asserts mem_we, with mem_addr set to its result address and mem_data set to its result value. mem_we is never asserted at any other time.
- R6: Once a result has been written to a slot, look_ready is 1 and look_value returns that result for the slot's tag, until the slot retires.
- R7: A retiring branch (kind 2'd2) marked mispredicted, without a fault, asserts flush and redirect_valid, with redirect_pc set to its result address. Every slot is discarded, and the next tag issued is the index after the branch.
- R8: A retiring slot whose fault flag is set asserts exc_take and flush. It asserts none of rf_we, mem_we or redirect_valid.
- R9: When the buffer is full and the head retires in the same cycle, alloc_ready is 1 and a new slot can be allocated in that cycle.
- R10: A result whose tag names a slot that is not occupied, or that already holds a result, has no effect.
- R11: A retiring branch that was predicted correctly releases its slot without flush, redirect or any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request to claim a slot at issue |
| alloc_kind | input | 2 | Kind: 0 register op, 1 store, 2 branch |
| alloc_dst | input | RW | Destination register index |
| alloc_ready | output | 1 | A slot can be claimed this cycle |
| alloc_tag | output | TW | Tag of the slot claimed this cycle |
| res_valid | input | 1 | Result broadcast valid |
| res_tag | input | TW | Tag the result belongs to |
| res_value | input | DW | Result value (store data for a store) |
| res_addr | input | AW | Store address or correct branch successor |
| res_exc | input | 1 | Instruction raised a fault |
| res_mispred | input | 1 | Branch was mispredicted |
| look_tag | input | TW | Tag to read an operand from |
| look_ready | output | 1 | That slot holds a result |
| look_value | output | DW | Result held by that slot |
| rf_we | output | 1 | Register write at retirement |
| rf_idx | output | RW | Register index written |
| rf_data | output | DW | Register data written |
| mem_we | output | 1 | Store performed at retirement |
| mem_addr | output | AW | Store address |
| mem_data | output | DW | Store data |
| flush | output | 1 | Discard all in-flight work |
| redirect_valid | output | 1 | Restart fetch at redirect_pc |
| redirect_pc | output | AW | Correct successor address |
| exc_take | output | 1 | Precise fault taken at retirement |

## Verification
The assertions check several properties on every cycle. At most one retirement action (register write, store or flush) occurs per cycle. A redirect always comes with a flush. A taken fault writes nothing. The cycle after a flush is empty and can allocate. Successive allocations advance the tag by one. The bench scenarios are needed for the rest. Only they can show that results arriving out of order still retire in issue order with the right payload, and that operand lookups return values before retirement. They also show that allocation works while full with the head retiring, and that stray broadcasts to free or finished slots change nothing. A reference model of slot occupancy in the bench tracks each of these.

// File: rtl/rob_core.sv
`timescale 1ns/1ps
module rob_core #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int RW    = 5,
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  input  logic [1:0]    alloc_kind,
  input  logic [RW-1:0] alloc_dst,
  output logic          alloc_ready,
  output logic [TW-1:0] alloc_tag,
  input  logic          res_valid,
  input  logic [TW-1:0] res_tag,
  input  logic [DW-1:0] res_value,
  input  logic [AW-1:0] res_addr,
  input  logic          res_exc,
  input  logic          res_mispred,
  input  logic [TW-1:0] look_tag,
  output logic          look_ready,
  output logic [DW-1:0] look_value,
  output logic          rf_we,
  output logic [RW-1:0] rf_idx,
  output logic [DW-1:0] rf_data,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic          flush,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_pc,
  output logic          exc_take
);
  localparam logic [1:0]  K_REG = 2'd0;
  localparam logic [1:0]  K_ST  = 2'd1;
  localparam logic [1:0]  K_BR  = 2'd2;
  localparam logic [TW:0] P_ONE = {{TW{1'b0}}, 1'b1};

  logic [TW:0]      head_q, tail_q;
  logic [DEPTH-1:0] valid_q, ready_q, exc_q, mis_q;
  logic [1:0]       kind_q [DEPTH];
  logic [RW-1:0]    dst_q  [DEPTH];
  logic [DW-1:0]    val_q  [DEPTH];
  logic [AW-1:0]    addr_q [DEPTH];

  wire [TW-1:0] hidx   = head_q[TW-1:0];
  wire [TW-1:0] tidx   = tail_q[TW-1:0];
  wire          full   = (head_q[TW] != tail_q[TW]) && (hidx == tidx);
  wire          fire   = valid_q[hidx] & ready_q[hidx];
  wire [1:0]    h_kind = kind_q[hidx];
  wire          h_exc  = exc_q[hidx];

  assign flush          = fire & (h_exc | ((h_kind == K_BR) & mis_q[hidx]));
  assign exc_take       = fire & h_exc;
  assign redirect_valid = flush & ~h_exc;
  assign redirect_pc    = addr_q[hidx];
  assign rf_we          = fire & ~h_exc & (h_kind == K_REG);
  assign rf_idx         = dst_q[hidx];
  assign rf_data        = val_q[hidx];
  assign mem_we         = fire & ~h_exc & (h_kind == K_ST);
  assign mem_addr       = addr_q[hidx];
  assign mem_data       = val_q[hidx];

  assign alloc_ready = ~flush & (~full | fire);
  assign alloc_tag   = tidx;
  assign look_ready  = valid_q[look_tag] & ready_q[look_tag];
  assign look_value  = val_q[look_tag];

  wire do_alloc = alloc_valid & alloc_ready;
  wire res_hit  = res_valid & valid_q[res_tag] & ~ready_q[res_tag] & ~flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      valid_q <= '0;
      ready_q <= '0;
      exc_q   <= '0;
      mis_q   <= '0;
    end else begin
      if (fire) begin
        valid_q[hidx] <= 1'b0;
        head_q        <= head_q + P_ONE;
      end
      if (res_hit) begin
        ready_q[res_tag] <= 1'b1;
        exc_q[res_tag]   <= res_exc;
        mis_q[res_tag]   <= res_mispred;
      end
      if (do_alloc) begin
        valid_q[tidx] <= 1'b1;
        ready_q[tidx] <= 1'b0;
        exc_q[tidx]   <= 1'b0;
        mis_q[tidx]   <= 1'b0;
        tail_q        <= tail_q + P_ONE;
      end
      if (flush) begin
        valid_q <= '0;
        tail_q  <= head_q + P_ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_alloc) begin
      kind_q[tidx] <= alloc_kind;
      dst_q[tidx]  <= alloc_dst;
    end
    if (res_hit) begin
      val_q[res_tag]  <= res_value;
      addr_q[res_tag] <= res_addr;
    end
  end
endmodule

// File: rtl/rob_core_chk.sv
`timescale 1ns/1ps
module rob_core_chk #(
  parameter int TW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_valid,
  input logic          alloc_ready,
  input logic [TW-1:0] alloc_tag,
  input logic          rf_we,
  input logic          mem_we,
  input logic          flush,
  input logic          redirect_valid,
  input logic          exc_take
);
  // R3: one retirement action per cycle
  a_r3_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, mem_we, flush}));

  a_r7_redirect_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> flush);

  a_r7_empty_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (alloc_ready && !rf_we && !mem_we && !flush));

  a_r8_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |-> (flush && !rf_we && !mem_we && !redirect_valid));

  a_r2_tag_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> (alloc_tag == TW'($past(alloc_tag) + 1'b1)));
endmodule

bind rob_core rob_core_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .alloc_tag(alloc_tag), .rf_we(rf_we), .mem_we(mem_we), .flush(flush),
  .redirect_valid(redirect_valid), .exc_take(exc_take)
);

// File: tb/sim_rob_core.sv
`timescale 1ns/1ps
module sim_rob_core;
  localparam int D = 8, DW = 32, AW = 32, RW = 5, TW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic alloc_valid = 0, alloc_ready;
  logic [1:0] alloc_kind = 0;
  logic [RW-1:0] alloc_dst = 0;
  logic [TW-1:0] alloc_tag;
  logic res_valid = 0, res_exc = 0, res_mispred = 0;
  logic [TW-1:0] res_tag = 0, look_tag = 0;
  logic [DW-1:0] res_value = 0, look_value, rf_data, mem_data;
  logic [AW-1:0] res_addr = 0, mem_addr, redirect_pc;
  logic look_ready, rf_we, mem_we, flush, redirect_valid, exc_take;
  logic [RW-1:0] rf_idx;

  always #10 clk = ~clk;

  rob_core #(.DEPTH(D), .DW(DW), .AW(AW), .RW(RW)) u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // stimulus globals
  logic a_v; logic [1:0] a_k; logic [RW-1:0] a_d;
  logic r_v, r_e, r_m; int r_t; logic [DW-1:0] r_val; logic [AW-1:0] r_ad; int l_t;

  // reference model
  bit m_valid [D]; bit m_ready [D]; bit m_exc [D]; bit m_mis [D];
  logic [1:0] m_kind [D]; logic [RW-1:0] m_dst [D];
  logic [DW-1:0] m_val [D]; logic [AW-1:0] m_addr [D];
  int m_head = 0, m_tail = 0;

  // sampled outputs from last step
  logic s_ar, s_rf, s_mw, s_fl, s_rv, s_ex, s_lr;
  logic [AW-1:0] s_pc;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    a_v = 0; a_k = 0; a_d = 0; r_v = 0; r_e = 0; r_m = 0; r_t = 0;
    r_val = 0; r_ad = 0; l_t = 0;
  endtask

  task automatic step();
    int h, cnt, ti;
    bit fire, e_fl, e_ar, e_rf, e_mw, e_lr;
    @(negedge clk);
    alloc_valid = a_v; alloc_kind = a_k; alloc_dst = a_d;
    res_valid = r_v; res_tag = TW'(r_t); res_value = r_val; res_addr = r_ad;
    res_exc = r_e; res_mispred = r_m; look_tag = TW'(l_t);
    #1;
    h = m_head % D; cnt = m_tail - m_head;
    fire = m_valid[h] && m_ready[h];
    e_fl = fire && (m_exc[h] || (m_kind[h] == 2'd2 && m_mis[h]));
    e_ar = !e_fl && (cnt < D || fire);
    e_rf = fire && !m_exc[h] && m_kind[h] == 2'd0;
    e_mw = fire && !m_exc[h] && m_kind[h] == 2'd1;
    e_lr = m_valid[l_t] && m_ready[l_t];
    chk("R2 alloc_ready", alloc_ready, e_ar);
    chk("R2 alloc_tag", alloc_tag, m_tail % D);
    chk("R3 R4 rf_we", rf_we, e_rf);
    if (e_rf) begin
      chk("R4 rf_idx", rf_idx, m_dst[h]);
      chk("R3 R4 rf_data", rf_data, m_val[h]);
    end
    chk("R5 mem_we", mem_we, e_mw);
    if (e_mw) begin
      chk("R5 mem_addr", mem_addr, m_addr[h]);
      chk("R5 mem_data", mem_data, m_val[h]);
    end
    chk("R7 R8 R11 flush", flush, e_fl);
    chk("R7 redirect_valid", redirect_valid, e_fl && !m_exc[h]);
    if (e_fl && !m_exc[h]) chk("R7 redirect_pc", redirect_pc, m_addr[h]);
    chk("R8 exc_take", exc_take, fire && m_exc[h]);
    chk("R6 R10 look_ready", look_ready, e_lr);
    if (e_lr) chk("R6 look_value", look_value, m_val[l_t]);
    s_ar = alloc_ready; s_rf = rf_we; s_mw = mem_we; s_fl = flush;
    s_rv = redirect_valid; s_ex = exc_take; s_lr = look_ready; s_pc = redirect_pc;
    // model update
    if (fire) begin m_valid[h] = 0; m_head++; end
    if (e_fl) begin
      for (int i = 0; i < D; i++) m_valid[i] = 0;
      m_tail = m_head;
    end else if (r_v && m_valid[r_t] && !m_ready[r_t]) begin
      m_ready[r_t] = 1; m_exc[r_t] = r_e; m_mis[r_t] = r_m;
      m_val[r_t] = r_val; m_addr[r_t] = r_ad;
    end
    if (a_v && e_ar) begin
      ti = m_tail % D;
      m_valid[ti] = 1; m_ready[ti] = 0; m_exc[ti] = 0; m_mis[ti] = 0;
      m_kind[ti] = a_k; m_dst[ti] = a_d; m_tail++;
    end
  endtask

  task automatic alloc1(logic [1:0] k, logic [RW-1:0] d);
    idle(); a_v = 1; a_k = k; a_d = d; step();
  endtask

  task automatic result1(int t, logic [DW-1:0] v, logic [AW-1:0] ad, logic e, logic m);
    idle(); r_v = 1; r_t = t; r_val = v; r_ad = ad; r_e = e; r_m = m; l_t = t; step();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < D; i++) begin
      m_valid[i] = 0; m_ready[i] = 0; m_exc[i] = 0; m_mis[i] = 0;
    end
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 alloc_ready", alloc_ready, 1);
    chk("R1 alloc_tag", alloc_tag, 0);
    chk("R1 rf_we", rf_we, 0);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 flush", flush | redirect_valid | exc_take, 0);
    chk("R1 look_ready", look_ready, 0);

    // R10: broadcast to an empty slot is ignored
    result1(5, 32'hdead, 0, 0, 0);
    idle(); l_t = 5; step();
    chk("R10 stray result ignored", s_lr, 0);

    // fill, out-of-order results, full with retire
    for (int i = 0; i < D; i++) alloc1(2'd0, RW'(i + 1));
    idle(); a_v = 1; step();
    chk("R2 full blocks alloc", s_ar, 0);
    result1(3, 32'h33, 0, 0, 0);
    idle(); l_t = 3; step();
    chk("R6 early lookup", s_lr, 1);
    result1(0, 32'h10, 0, 0, 0);
    idle(); a_v = 1; a_k = 2'd1; a_d = 0; step();
    chk("R9 alloc while full and retiring", s_ar, 1);
    chk("R3 head retires", s_rf, 1);
    for (int i = 0; i < D; i++) result1(i, 32'h100 + i, 32'h200 + i, 0, 0);
    repeat (D + 2) begin idle(); step(); end

    // R11 correct branch, R7 mispredict, R8 fault
    alloc1(2'd2, 0);
    result1((m_tail - 1) % D, 0, 32'h4000, 0, 0);
    idle(); step();
    chk("R11 no flush on correct branch", s_fl, 0);
    alloc1(2'd2, 0); alloc1(2'd0, 7); alloc1(2'd1, 0);
    result1((m_tail - 3) % D, 0, 32'h1234, 0, 1);
    idle(); step();
    chk("R7 flush", s_fl, 1);
    chk("R7 redirect", s_pc, 32'h1234);
    idle(); step();
    alloc1(2'd1, 0);
    result1((m_tail - 1) % D, 32'h55, 32'h66, 1, 0);
    idle(); step();
    chk("R8 fault taken", s_ex, 1);
    chk("R8 no store", s_mw, 0);

    // constrained random
    for (int c = 0; c < 4000; c++) begin
      int cnt;
      idle();
      cnt = m_tail - m_head;
      a_v = ($urandom % 3) != 0;
      a_k = 2'($urandom % 3);
      a_d = RW'($urandom);
      r_v = ($urandom % 4) != 0;
      if (cnt > 0 && ($urandom % 8) != 0) r_t = (m_head + int'($urandom % cnt)) % D;
      else r_t = int'($urandom % D);
      r_val = $urandom; r_ad = $urandom;
      r_e = ($urandom % 20) == 0;
      r_m = ($urandom % 5) == 0;
      l_t = int'($urandom % D);
      step();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule